// File: doc/BRIEF.md
# Stack and Control-Transfer Sequencer

This block carries out the multi-cycle control transfers of a small 8-bit processor whose stack lives in page one of a 16-bit byte-addressed memory: subroutine call and return, software break, return from interrupt, status push and pull, the plain jump and relative branch that only retarget the program counter, and the vector fetch that follows reset. It owns the program counter, the stack pointer and the status byte. It reaches memory through a single byte port whose read data is valid in the cycle the address is driven.

A transfer starts with a one-cycle `start` strobe. The strobe carries an operation code, the address following the opcode byte (`next_pc`) and the call or jump target. After every jump, call, return, break or return from interrupt, the new program counter's high byte is compared with a trap-page register. On a nonzero match the sequencer raises `trap_req` and waits. While it waits, outside logic may rewrite the stack pointer and status. On `trap_ack` it performs an automatic return and does not check the trap page again.

States: `ST_RST_LO` and `ST_RST_HI` (reset vector fetch, then `ST_IDLE`). `ST_IDLE` branches on the operation: to `ST_PUSH_HI` for call and break, to `ST_PUSH_STS` for status push, to `ST_PULL_LO` for return, to `ST_PULL_STS` for return from interrupt and status pull, to `ST_CHECK` for jump, and back to itself for a branch. The push chain runs `ST_PUSH_HI` to `ST_PUSH_LO`, then on to `ST_PUSH_STS` for a break or to `ST_CHECK` for a call. `ST_PUSH_STS` goes to `ST_VEC_LO` for a break and to `ST_IDLE` otherwise. `ST_VEC_LO` leads to `ST_VEC_HI` and then `ST_CHECK`. `ST_PULL_STS` goes to `ST_PULL_LO` for a return from interrupt and to `ST_IDLE` otherwise. `ST_PULL_LO` leads to `ST_PULL_HI`, which goes to `ST_CHECK`, or to `ST_IDLE` when serving a trap. `ST_CHECK` goes to `ST_TRAP_WAIT` on a hit and to `ST_IDLE` otherwise. `ST_TRAP_WAIT` goes to `ST_PULL_LO` on acknowledge.

Top module: `xfer_seq`

## Requirements
- R1: The stack byte address is 0x0100 + SP. A push writes at the current SP and then decrements it. A pull first increments SP and then reads at the new value. SP wraps modulo 256.
- R2: A call (op code 1) writes the return address, `next_pc`+1, high byte first and then low byte. It then loads PC with the target.
- R3: A return (op code 2) pulls the low byte and then the high byte. PC becomes that address plus one.
- R4: A break (op code 3) sets status bit 4 and pushes `next_pc`+1 high then low. It then pushes the status byte, sets status bit 2, and loads PC from memory 0xFFFE (low byte) and 0xFFFF (high byte).
- R5: A return from interrupt (op code 4) pulls the status byte, then the PC low and high bytes, and adds nothing to the PC.
- R6: A status push (op code 5) writes the status byte with bit 5 forced to one and leaves PC at `next_pc`. A status pull (op code 6) loads the pulled byte unchanged.
- R7: Reset clears SP and status to zero. PC is then loaded from 0xFFFC (low) and 0xFFFD (high), and `done` pulses when it is loaded.
- R8: After a jump (op code 0), call, return, break or return from interrupt, `trap_req` rises only if `trap_page` is nonzero and equals PC[15:8]. A relative branch (op code 7, PC loads the target) never raises it.
- R9: `trap_req` stays high until a one-cycle `trap_ack`. `ovr_we` loads `ovr_sp` and `ovr_p` only while the request is pending and is ignored at other times.
- R10: On `trap_ack` the sequencer pulls a return address (low then high) and sets PC to it plus one. It does not compare the result with the trap page.
- R11: `busy` is high from the start strobe until the operation ends. `done` is a one-cycle pulse with PC, SP and status final. A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 3 | Operation code |
| next_pc | input | 16 | Address following the opcode byte |
| target | input | 16 | Call, jump or branch destination |
| trap_page | input | 8 | Page that traps control transfers; zero disables |
| trap_ack | input | 1 | Acknowledge of a pending trap |
| ovr_we | input | 1 | Override write of SP and status during a trap |
| ovr_sp | input | 8 | Override stack pointer value |
| ovr_p | input | 8 | Override status value |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| pc_out | output | 16 | Program counter |
| sp_out | output | 8 | Stack pointer |
| p_out | output | 8 | Status byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| trap_req | output | 1 | Trap request pending |

## Verification
The assertions assume that `trap_page` does not change between the end of a transfer and the rise of the request it produces. They also assume that a new start strobe never arrives in the same cycle as a `done` pulse. The stimulus holds `trap_page` steady for the whole of each operation and leaves an idle cycle after every `done` before the next strobe. The memory model answers reads combinationally, and a pending trap is acknowledged only after the request has been seen to stay high for a cycle.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    typedef enum logic [2:0] {
        OP_JUMP   = 3'd0,
        OP_CALL   = 3'd1,
        OP_RET    = 3'd2,
        OP_BRK    = 3'd3,
        OP_RTI    = 3'd4,
        OP_PUSHP  = 3'd5,
        OP_PULLP  = 3'd6,
        OP_BRANCH = 3'd7
    } xfer_op_e;

    typedef enum logic [3:0] {
        ST_RST_LO,
        ST_RST_HI,
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_STS,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_PULL_STS,
        ST_PULL_LO,
        ST_PULL_HI,
        ST_CHECK,
        ST_TRAP_WAIT
    } seq_state_e;

    localparam int FLG_I   = 2;
    localparam int FLG_B   = 4;
    localparam int FLG_ONE = 5;

endpackage

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
    parameter int             DW       = 8,
    parameter logic [DW-1:0]  STK_PAGE = 8'h01
) (
    input  logic [DW-1:0]   sp,
    output logic [2*DW-1:0] push_addr,
    output logic [2*DW-1:0] pull_addr,
    output logic [DW-1:0]   sp_dec,
    output logic [DW-1:0]   sp_inc
);
    always_comb begin
        sp_dec    = sp - 1'b1;
        sp_inc    = sp + 1'b1;
        push_addr = {STK_PAGE, sp};
        pull_addr = {STK_PAGE, sp_inc};
    end
endmodule

// File: rtl/page_trap_cmp.sv
module page_trap_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] pc_hi,
    input  logic [DW-1:0] trap_page,
    output logic          hit
);
    always_comb hit = (trap_page != '0) && (pc_hi == trap_page);
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter int              DW       = 8,
    parameter logic [DW-1:0]   STK_PAGE = 8'h01,
    parameter logic [2*DW-1:0] RST_VEC  = 16'hFFFC,
    parameter logic [2*DW-1:0] BRK_VEC  = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [2*DW-1:0]   next_pc,
    input  logic [2*DW-1:0]   target,
    input  logic [DW-1:0]     trap_page,
    input  logic              trap_ack,
    input  logic              ovr_we,
    input  logic [DW-1:0]     ovr_sp,
    input  logic [DW-1:0]     ovr_p,
    output logic [2*DW-1:0]   mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [2*DW-1:0]   pc_out,
    output logic [DW-1:0]     sp_out,
    output logic [DW-1:0]     p_out,
    output logic              busy,
    output logic              done,
    output logic              trap_req
);
    localparam int AW = 2 * DW;

    seq_state_e     state, nxt;
    xfer_op_e       op_q, op_in;
    logic [AW-1:0]  pc_q, ret_q;
    logic [DW-1:0]  sp_q, p_q, lo_q;
    logic           trap_svc_q, done_q;
    logic [AW-1:0]  push_addr, pull_addr;
    logic [DW-1:0]  sp_dec, sp_inc;
    logic           page_hit;

    assign op_in = xfer_op_e'(op);

    stk_ptr_unit #(.DW(DW), .STK_PAGE(STK_PAGE)) u_sp (
        .sp        (sp_q),
        .push_addr (push_addr),
        .pull_addr (pull_addr),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc)
    );

    page_trap_cmp #(.DW(DW)) u_trap (
        .pc_hi     (pc_q[AW-1:DW]),
        .trap_page (trap_page),
        .hit       (page_hit)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RST_LO;
        else        state <= nxt;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RST_LO:   nxt = ST_RST_HI;
            ST_RST_HI:   nxt = ST_IDLE;
            ST_IDLE: begin
                if (start) begin
                    unique case (op_in)
                        OP_JUMP:          nxt = ST_CHECK;
                        OP_BRANCH:        nxt = ST_IDLE;
                        OP_CALL, OP_BRK:  nxt = ST_PUSH_HI;
                        OP_PUSHP:         nxt = ST_PUSH_STS;
                        OP_RET:           nxt = ST_PULL_LO;
                        OP_RTI, OP_PULLP: nxt = ST_PULL_STS;
                        default:          nxt = ST_IDLE;
                    endcase
                end
            end
            ST_PUSH_HI:  nxt = ST_PUSH_LO;
            ST_PUSH_LO:  nxt = (op_q == OP_BRK) ? ST_PUSH_STS : ST_CHECK;
            ST_PUSH_STS: nxt = (op_q == OP_BRK) ? ST_VEC_LO : ST_IDLE;
            ST_VEC_LO:   nxt = ST_VEC_HI;
            ST_VEC_HI:   nxt = ST_CHECK;
            ST_PULL_STS: nxt = (op_q == OP_RTI) ? ST_PULL_LO : ST_IDLE;
            ST_PULL_LO:  nxt = ST_PULL_HI;
            ST_PULL_HI:  nxt = trap_svc_q ? ST_IDLE : ST_CHECK;
            ST_CHECK:    nxt = page_hit ? ST_TRAP_WAIT : ST_IDLE;
            ST_TRAP_WAIT: nxt = trap_ack ? ST_PULL_LO : ST_TRAP_WAIT;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            ST_RST_LO:   mem_addr = RST_VEC;
            ST_RST_HI:   mem_addr = RST_VEC + 1'b1;
            ST_VEC_LO:   mem_addr = BRK_VEC;
            ST_VEC_HI:   mem_addr = BRK_VEC + 1'b1;
            ST_PUSH_HI: begin
                mem_addr  = push_addr;
                mem_we    = 1'b1;
                mem_wdata = ret_q[AW-1:DW];
            end
            ST_PUSH_LO: begin
                mem_addr  = push_addr;
                mem_we    = 1'b1;
                mem_wdata = ret_q[DW-1:0];
            end
            ST_PUSH_STS: begin
                mem_addr  = push_addr;
                mem_we    = 1'b1;
                mem_wdata = p_q | (DW'(1) << FLG_ONE);
            end
            ST_PULL_STS, ST_PULL_LO, ST_PULL_HI: mem_addr = pull_addr;
            default: ;
        endcase
        busy     = (state != ST_IDLE);
        trap_req = (state == ST_TRAP_WAIT);
        done     = done_q;
        pc_out   = pc_q;
        sp_out   = sp_q;
        p_out    = p_q;
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= '0;
            sp_q       <= '0;
            p_q        <= '0;
            op_q       <= OP_JUMP;
            ret_q      <= '0;
            lo_q       <= '0;
            trap_svc_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= (nxt == ST_IDLE) && ((state != ST_IDLE) || start);
            unique case (state)
                ST_RST_LO: pc_q[DW-1:0]  <= mem_rdata;
                ST_RST_HI: pc_q[AW-1:DW] <= mem_rdata;
                ST_IDLE: begin
                    if (start) begin
                        op_q       <= op_in;
                        ret_q      <= next_pc + 1'b1;
                        trap_svc_q <= 1'b0;
                        pc_q       <= (op_in == OP_PUSHP || op_in == OP_PULLP) ? next_pc : target;
                        if (op_in == OP_BRK) p_q[FLG_B] <= 1'b1;
                    end
                end
                ST_PUSH_HI, ST_PUSH_LO: sp_q <= sp_dec;
                ST_PUSH_STS: begin
                    sp_q <= sp_dec;
                    if (op_q == OP_BRK) p_q[FLG_I] <= 1'b1;
                end
                ST_VEC_LO: pc_q[DW-1:0]  <= mem_rdata;
                ST_VEC_HI: pc_q[AW-1:DW] <= mem_rdata;
                ST_PULL_STS: begin
                    sp_q <= sp_inc;
                    p_q  <= mem_rdata;
                end
                ST_PULL_LO: begin
                    sp_q <= sp_inc;
                    lo_q <= mem_rdata;
                end
                ST_PULL_HI: begin
                    sp_q <= sp_inc;
                    if (op_q == OP_RTI && !trap_svc_q) pc_q <= {mem_rdata, lo_q};
                    else                               pc_q <= {mem_rdata, lo_q} + 1'b1;
                end
                ST_TRAP_WAIT: begin
                    if (ovr_we) begin
                        sp_q <= ovr_sp;
                        p_q  <= ovr_p;
                    end
                    if (trap_ack) trap_svc_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_we,
    input logic [2*DW-1:0] mem_addr,
    input logic [2*DW-1:0] pc_out,
    input logic [DW-1:0]   sp_out,
    input logic [DW-1:0]   trap_page,
    input logic            trap_req,
    input logic            trap_ack,
    input logic            busy,
    input logic            done
);
    assert_push_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == {8'h01, sp_out}));

    assert_push_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == $past(sp_out) - 8'd1));

    assert_trap_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_req) |-> (trap_page != 8'd0 && pc_out[15:8] == trap_page));

    assert_trap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> trap_req);

    assert_trap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (busy && !mem_we));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind xfer_seq xfer_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .pc_out    (pc_out),
    .sp_out    (sp_out),
    .trap_page (trap_page),
    .trap_req  (trap_req),
    .trap_ack  (trap_ack),
    .busy      (busy),
    .done      (done)
);

// File: tb/xfer_seq_tb.sv
`timescale 1ns/1ps
module xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] next_pc = '0, target = '0;
    logic [7:0]  trap_page = '0;
    logic        trap_ack = 1'b0, ovr_we = 1'b0;
    logic [7:0]  ovr_sp = '0, ovr_p = '0;
    logic [15:0] mem_addr, pc_out;
    logic        mem_we, busy, done, trap_req;
    logic [7:0]  mem_wdata, mem_rdata, sp_out, p_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct packed { logic [15:0] pc; logic [7:0] sp; logic [7:0] p; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    logic [7:0] mem [0:1023];

    function automatic int idx(input logic [15:0] a);
        return int'({a[15], a[8:0]});
    endfunction

    always #4 clk = ~clk;

    assign mem_rdata = mem[idx(mem_addr)];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
            mem[idx(16'hFFFC)] <= 8'h34;
            mem[idx(16'hFFFD)] <= 8'h12;
            mem[idx(16'hFFFE)] <= 8'h00;
            mem[idx(16'hFFFF)] <= 8'h40;
            mem[idx(16'h0101)] <= 8'h10;
            mem[idx(16'h0102)] <= 8'h80;
            mem[idx(16'h0103)] <= 8'hFF;
            mem[idx(16'h0104)] <= 8'h77;
            mem[idx(16'h0105)] <= 8'h10;
            mem[idx(16'h0106)] <= 8'h78;
        end else if (mem_we) begin
            mem[idx(mem_addr)] <= mem_wdata;
        end
    end

    xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .next_pc(next_pc),
        .target(target), .trap_page(trap_page), .trap_ack(trap_ack),
        .ovr_we(ovr_we), .ovr_sp(ovr_sp), .ovr_p(ovr_p),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out),
        .busy(busy), .done(done), .trap_req(trap_req)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor: pops one expected result per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected done", 16'd1, 16'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " pc"}, pc_out, e.pc);
                check({t, " sp"}, {8'h00, sp_out}, {8'h00, e.sp});
                check({t, " p"},  {8'h00, p_out},  {8'h00, e.p});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            summary();
            $finish;
        end
    end

    task automatic push_exp(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p, input string t);
        exp_t e;
        e.pc = pc; e.sp = sp; e.p = p;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic launch(input logic [2:0] o, input logic [15:0] npc, input logic [15:0] tgt,
                          input logic [7:0] pg, input bit poke);
        @(negedge clk);
        op = o; next_pc = npc; target = tgt; trap_page = pg; start = 1'b1;
        @(negedge clk);
        if (poke) begin
            op = 3'd0; target = 16'hDEAD;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic do_op(input logic [2:0] o, input logic [15:0] npc, input logic [15:0] tgt,
                         input logic [7:0] pg, input bit poke,
                         input logic [15:0] epc, input logic [7:0] esp, input logic [7:0] ep,
                         input string t);
        push_exp(epc, esp, ep, t);
        launch(o, npc, tgt, pg, poke);
        while (!done) begin
            if (trap_req) check({t, " R8 no trap"}, 16'd1, 16'd0);
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_trap(input logic [2:0] o, input logic [15:0] npc, input logic [15:0] tgt,
                           input logic [7:0] pg,
                           input logic [15:0] tpc, input logic [7:0] tsp, input logic [7:0] tp,
                           input bit ow, input logic [7:0] osp, input logic [7:0] op_v,
                           input logic [15:0] epc, input logic [7:0] esp, input logic [7:0] ep,
                           input string t);
        launch(o, npc, tgt, pg, 1'b0);
        while (!trap_req && !done) @(negedge clk);
        check({t, " R8 trap raised"}, {15'd0, trap_req}, 16'd1);
        check({t, " R8 trap pc"}, pc_out, tpc);
        check({t, " trap sp"}, {8'h00, sp_out}, {8'h00, tsp});
        check({t, " trap p"}, {8'h00, p_out}, {8'h00, tp});
        @(negedge clk);
        check({t, " R9 trap held"}, {15'd0, trap_req}, 16'd1);
        push_exp(epc, esp, ep, {t, " R10"});
        trap_ack = 1'b1; ovr_we = ow; ovr_sp = osp; ovr_p = op_v;
        @(negedge clk);
        trap_ack = 1'b0; ovr_we = 1'b0;
        while (!done) begin
            if (trap_req) check({t, " R10 no recheck"}, 16'd1, 16'd0);
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        push_exp(16'h1234, 8'h00, 8'h00, "R7 reset vector");
        repeat (3) @(negedge clk);
        check("R7 reset sp", {8'h00, sp_out}, 16'h0000);
        check("R7 reset p", {8'h00, p_out}, 16'h0000);
        check("R11 busy in reset", {15'd0, busy}, 16'd1);
        rst_n = 1'b1;
        while (!done) @(negedge clk);
        @(negedge clk);

        // R2 call with a start strobe held into the busy period (R11 ignored)
        do_op(3'd1, 16'h1235, 16'h2000, 8'h00, 1'b1, 16'h2000, 8'hFE, 8'h00, "R2 call");
        check("R2 R1 high byte at 0x0100", {8'h00, mem[idx(16'h0100)]}, 16'h0012);
        check("R2 R1 low byte at 0x01FF after wrap", {8'h00, mem[idx(16'h01FF)]}, 16'h0036);

        do_op(3'd2, 16'h2001, 16'h0000, 8'h00, 1'b0, 16'h1237, 8'h00, 8'h00, "R3 return");
        do_op(3'd5, 16'h1238, 16'h0000, 8'h00, 1'b0, 16'h1238, 8'hFF, 8'h00, "R6 status push");
        check("R6 pushed bit5 set", {8'h00, mem[idx(16'h0100)]}, 16'h0020);
        do_op(3'd6, 16'h1239, 16'h0000, 8'h00, 1'b0, 16'h1239, 8'h00, 8'h20, "R6 status pull");

        // R4 break landing on trap page 0x40; override SP and status while pending
        do_trap(3'd3, 16'h3001, 16'h0000, 8'h40, 16'h4000, 8'hFD, 8'h34,
                1'b1, 8'hFE, 8'h05, 16'h3003, 8'h00, 8'h05, "R4 break");
        check("R4 pushed status", {8'h00, mem[idx(16'h01FE)]}, 16'h0030);
        check("R4 pushed pc low", {8'h00, mem[idx(16'h01FF)]}, 16'h0002);

        do_op(3'd1, 16'h5000, 16'h6000, 8'h00, 1'b0, 16'h6000, 8'hFE, 8'h05, "R2 call two");
        do_op(3'd5, 16'h6001, 16'h0000, 8'h00, 1'b0, 16'h6001, 8'hFD, 8'h05, "R6 push two");
        check("R6 pushed 0x25", {8'h00, mem[idx(16'h01FE)]}, 16'h0025);
        do_op(3'd4, 16'h6002, 16'h0000, 8'h00, 1'b0, 16'h5001, 8'h00, 8'h25, "R5 rti");

        do_trap(3'd0, 16'h5002, 16'h77AA, 8'h77, 16'h77AA, 8'h00, 8'h25,
                1'b0, 8'h00, 8'h00, 16'h8011, 8'h02, 8'h25, "R8 jump");
        do_op(3'd7, 16'h8012, 16'h77BB, 8'h77, 1'b0, 16'h77BB, 8'h02, 8'h25, "R8 branch");

        // R9 override outside a pending trap has no effect
        @(negedge clk);
        ovr_we = 1'b1; ovr_sp = 8'hAA; ovr_p = 8'hBB;
        @(negedge clk);
        ovr_we = 1'b0;
        check("R9 override ignored sp", {8'h00, sp_out}, 16'h0002);
        check("R9 override ignored p", {8'h00, p_out}, 16'h0025);

        do_op(3'd0, 16'h77BC, 16'h0050, 8'h00, 1'b0, 16'h0050, 8'h02, 8'h25, "R8 page zero");
        do_op(3'd0, 16'h0051, 16'h7700, 8'h78, 1'b0, 16'h7700, 8'h02, 8'h25, "R8 page mismatch");

        // R3 return onto trap page, R10 auto-return lands on the same page without retrap
        do_trap(3'd2, 16'h7701, 16'h0000, 8'h78, 16'h7800, 8'h04, 8'h25,
                1'b0, 8'h00, 8'h00, 16'h7811, 8'h06, 8'h25, "R3 return trap");

        repeat (2) @(negedge clk);
        check("R11 scoreboard drained", 16'(exp_q.size()), 16'd0);
        summary();
        $finish;
    end
endmodule